// File: doc/BRIEF.md
# MMU Control Register File

This block holds the software-visible translation control state for two sides, instruction fetch and data access. Each side has its own bank of slots that one indexed access port reaches. A side-select bit picks the bank and a 4-bit index picks the slot inside it. Reads are combinational. Writes take effect at the next rising clock edge.

The translation logic loads fault status and fault address values into either bank through dedicated update inputs. The block also drives, continuously, the values that translation needs:
- the tag access value of each side;
- the translation-storage-buffer base, split flag and size of each side;
- the 13-bit context, which always comes from the data-side primary context slot, for both sides.

Slot 0 holds no storage. A read of slot 0 returns a tag target word that is rebuilt from the tag access slot at the moment of the read. Each slot follows its own write rules. On the instruction side, several slots are read-only or absent.

Top module: `mmu_creg_file`

## Requirements
- R1: After reset, every slot of both sides reads zero, and every exported value is zero.
- R2: A read of index 0 returns the side's tag access value with its bits 12:0 moved to bits 60:48, ORed with the tag access value shifted right by 22. On both sides, a write to index 0 changes nothing.
- R3: A software write to index 3 (fault status) stores the written value if bit 0 is 1, and stores zero if bit 0 is 0.
- R4: On the data side, a write to index 3 with bit 0 equal to 0 also clears index 4 (fault address). A write with bit 0 equal to 1 leaves index 4 unchanged.
- R5: On the instruction side, writes to indices 1, 2, 4, 7 and 8 are ignored. Indices 1, 2, 7 and 8 always read zero there.
- R6: On the data side, indices 1, 2, 4, 5, 6, 7 and 8 store the written value and read it back unchanged.
- R7: On the instruction side, indices 5 (buffer base) and 6 (tag access) store the written value and read it back unchanged.
- R8: Indices 9 to 15 read zero on both sides. Writes to them change no slot.
- R9: The exported context equals bits 12:0 of the data-side index 1. Instruction-side writes do not change it.
- R10: Each side exports its tag access value. It also exports, from its index 5, the base as bits 63:13 with the low 13 bits zero, the split flag from bit 12 and the size from bits 3:0.
- R11: A fault update input loads that side's fault status and fault address on the next edge. It overrides a software write to either slot in the same cycle, including the data-side clear of R4.
- R12: A write to one side leaves every slot and every export of the other side unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_we_i | input | 1 | Write strobe for the access port |
| acc_dside_i | input | 1 | Side select: 1 selects the data side, 0 the instruction side |
| acc_idx_i | input | 4 | Slot index |
| acc_wdata_i | input | 64 | Write data |
| acc_rdata_o | output | 64 | Combinational read data of the selected slot |
| i_flt_upd_i | input | 1 | Instruction-side fault capture strobe |
| i_flt_status_i | input | 64 | Instruction-side fault status to capture |
| i_flt_addr_i | input | 64 | Instruction-side fault address to capture |
| d_flt_upd_i | input | 1 | Data-side fault capture strobe |
| d_flt_status_i | input | 64 | Data-side fault status to capture |
| d_flt_addr_i | input | 64 | Data-side fault address to capture |
| xl_ctx_o | output | 13 | Translation context, shared by both sides |
| i_tag_access_o | output | 64 | Instruction-side tag access value |
| i_tsb_base_o | output | 64 | Instruction-side buffer base, low 13 bits zero |
| i_tsb_split_o | output | 1 | Instruction-side split flag |
| i_tsb_size_o | output | 4 | Instruction-side size field |
| d_tag_access_o | output | 64 | Data-side tag access value |
| d_tsb_base_o | output | 64 | Data-side buffer base, low 13 bits zero |
| d_tsb_split_o | output | 1 | Data-side split flag |
| d_tsb_size_o | output | 4 | Data-side size field |

## Verification
Hardware fault capture and a software write to the fault status or fault address slot can fall in the same cycle. On the data side, that software write may also be the status write that clears the fault address. The bench forces the collision in directed cases: a capture lands together with a status write that has bit 0 clear, and together with a write to the fault address slot. During the random phase, both capture strobes fire in about a quarter of the cycles while writes fall on any slot. After each such cycle, the bench reads back both slots and compares them with its model, in which the captured values always win.

// File: rtl/mmu_creg_pkg.sv
package mmu_creg_pkg;
  localparam int unsigned DEF_DATA_W    = 64;
  localparam int unsigned DEF_IDX_W     = 4;
  localparam int unsigned DEF_CTX_W     = 13;
  localparam int unsigned TT_CTX_LSB    = 48;
  localparam int unsigned TT_VA_SHIFT   = 22;
  localparam int unsigned TSB_BASE_LSB  = 13;
  localparam int unsigned TSB_SPLIT_BIT = 12;
  localparam int unsigned TSB_SIZE_W    = 4;

  // slot numbering is decoded by software; keep it fixed
  localparam int unsigned SLOT_TGT    = 0;
  localparam int unsigned SLOT_PCTX   = 1;
  localparam int unsigned SLOT_SCTX   = 2;
  localparam int unsigned SLOT_FSTAT  = 3;
  localparam int unsigned SLOT_FADDR  = 4;
  localparam int unsigned SLOT_BASE   = 5;
  localparam int unsigned SLOT_TAGACC = 6;
  localparam int unsigned SLOT_VWP    = 7;
  localparam int unsigned SLOT_PWP    = 8;

  typedef struct packed {
    logic [DEF_DATA_W-1:0] base;
    logic                  split;
    logic [TSB_SIZE_W-1:0] size;
  } tsb_fields_t;
endpackage

// File: rtl/mmu_creg_tgt.sv
module mmu_creg_tgt
  import mmu_creg_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned CTX_W  = DEF_CTX_W
) (
  input  logic [DATA_W-1:0] tag_access_i,
  output logic [DATA_W-1:0] tag_target_o
);
  logic [DATA_W-1:0] ctx_part;
  logic [DATA_W-1:0] va_part;

  assign ctx_part     = DATA_W'(tag_access_i[CTX_W-1:0]) << TT_CTX_LSB;
  assign va_part      = tag_access_i >> TT_VA_SHIFT;
  assign tag_target_o = ctx_part | va_part;
endmodule

// File: rtl/mmu_creg_bank.sv
module mmu_creg_bank
  import mmu_creg_pkg::*;
#(
  parameter bit          IS_DATA = 1'b1,
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned IDX_W   = DEF_IDX_W,
  parameter int unsigned CTX_W   = DEF_CTX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              flt_upd_i,
  input  logic [DATA_W-1:0] flt_status_i,
  input  logic [DATA_W-1:0] flt_addr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] tag_access_o,
  output logic [CTX_W-1:0]  pri_ctx_o,
  output logic [DATA_W-1:0] tsb_o
);
  localparam logic [IDX_W-1:0] L_TGT    = IDX_W'(SLOT_TGT);
  localparam logic [IDX_W-1:0] L_PCTX   = IDX_W'(SLOT_PCTX);
  localparam logic [IDX_W-1:0] L_SCTX   = IDX_W'(SLOT_SCTX);
  localparam logic [IDX_W-1:0] L_FSTAT  = IDX_W'(SLOT_FSTAT);
  localparam logic [IDX_W-1:0] L_FADDR  = IDX_W'(SLOT_FADDR);
  localparam logic [IDX_W-1:0] L_BASE   = IDX_W'(SLOT_BASE);
  localparam logic [IDX_W-1:0] L_TAGACC = IDX_W'(SLOT_TAGACC);
  localparam logic [IDX_W-1:0] L_VWP    = IDX_W'(SLOT_VWP);
  localparam logic [IDX_W-1:0] L_PWP    = IDX_W'(SLOT_PWP);

  logic [DATA_W-1:0] pri_q, pri_d, sec_q, sec_d;
  logic [DATA_W-1:0] sfsr_q, sfsr_d, sfar_q, sfar_d;
  logic [DATA_W-1:0] tsb_q, tsb_d, tag_q, tag_d;
  logic [DATA_W-1:0] vwp_q, vwp_d, pwp_q, pwp_d;
  logic [DATA_W-1:0] tgt_val;
  logic              fstat_clear;

  mmu_creg_tgt #(.DATA_W(DATA_W), .CTX_W(CTX_W)) i_tgt (
    .tag_access_i (tag_q),
    .tag_target_o (tgt_val)
  );

  assign fstat_clear = we_i && (idx_i == L_FSTAT) && !wdata_i[0];

  always_comb begin
    pri_d  = pri_q;
    sec_d  = sec_q;
    sfsr_d = sfsr_q;
    sfar_d = sfar_q;
    tsb_d  = tsb_q;
    tag_d  = tag_q;
    vwp_d  = vwp_q;
    pwp_d  = pwp_q;
    if (we_i) begin
      unique case (idx_i)
        L_PCTX:   if (IS_DATA) pri_d = wdata_i;
        L_SCTX:   if (IS_DATA) sec_d = wdata_i;
        L_FSTAT: begin
          sfsr_d = wdata_i[0] ? wdata_i : '0;
          if (IS_DATA && fstat_clear) sfar_d = '0;
        end
        L_FADDR:  if (IS_DATA) sfar_d = wdata_i;
        L_BASE:   tsb_d = wdata_i;
        L_TAGACC: tag_d = wdata_i;
        L_VWP:    if (IS_DATA) vwp_d = wdata_i;
        L_PWP:    if (IS_DATA) pwp_d = wdata_i;
        default: ;
      endcase
    end
    // capture from translation wins over software
    if (flt_upd_i) begin
      sfsr_d = flt_status_i;
      sfar_d = flt_addr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pri_q  <= '0;
      sec_q  <= '0;
      sfsr_q <= '0;
      sfar_q <= '0;
      tsb_q  <= '0;
      tag_q  <= '0;
      vwp_q  <= '0;
      pwp_q  <= '0;
    end else begin
      pri_q  <= pri_d;
      sec_q  <= sec_d;
      sfsr_q <= sfsr_d;
      sfar_q <= sfar_d;
      tsb_q  <= tsb_d;
      tag_q  <= tag_d;
      vwp_q  <= vwp_d;
      pwp_q  <= pwp_d;
    end
  end

  always_comb begin
    unique case (idx_i)
      L_TGT:    rdata_o = tgt_val;
      L_PCTX:   rdata_o = IS_DATA ? pri_q : '0;
      L_SCTX:   rdata_o = IS_DATA ? sec_q : '0;
      L_FSTAT:  rdata_o = sfsr_q;
      L_FADDR:  rdata_o = sfar_q;
      L_BASE:   rdata_o = tsb_q;
      L_TAGACC: rdata_o = tag_q;
      L_VWP:    rdata_o = IS_DATA ? vwp_q : '0;
      L_PWP:    rdata_o = IS_DATA ? pwp_q : '0;
      default:  rdata_o = '0;
    endcase
  end

  assign tag_access_o = tag_q;
  assign pri_ctx_o    = pri_q[CTX_W-1:0];
  assign tsb_o        = tsb_q;

  assert_flt_prio_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_upd_i |=> (sfsr_q == $past(flt_status_i)) && (sfar_q == $past(flt_addr_i)));

  assert_fstat_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fstat_clear && !flt_upd_i) |=> (sfsr_q == '0));

  generate
    if (IS_DATA) begin : g_data_chk
      assert_faddr_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fstat_clear && !flt_upd_i) |=> (sfar_q == '0));
    end else begin : g_inst_chk
      assert_faddr_ro_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && (idx_i == L_FADDR) && !flt_upd_i) |=> $stable(sfar_q));
    end
  endgenerate
endmodule

// File: rtl/mmu_creg_file.sv
module mmu_creg_file
  import mmu_creg_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned IDX_W  = DEF_IDX_W,
  parameter int unsigned CTX_W  = DEF_CTX_W,
  parameter int unsigned SIZE_W = TSB_SIZE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_we_i,
  input  logic              acc_dside_i,
  input  logic [IDX_W-1:0]  acc_idx_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  output logic [DATA_W-1:0] acc_rdata_o,
  input  logic              i_flt_upd_i,
  input  logic [DATA_W-1:0] i_flt_status_i,
  input  logic [DATA_W-1:0] i_flt_addr_i,
  input  logic              d_flt_upd_i,
  input  logic [DATA_W-1:0] d_flt_status_i,
  input  logic [DATA_W-1:0] d_flt_addr_i,
  output logic [CTX_W-1:0]  xl_ctx_o,
  output logic [DATA_W-1:0] i_tag_access_o,
  output logic [DATA_W-1:0] i_tsb_base_o,
  output logic              i_tsb_split_o,
  output logic [SIZE_W-1:0] i_tsb_size_o,
  output logic [DATA_W-1:0] d_tag_access_o,
  output logic [DATA_W-1:0] d_tsb_base_o,
  output logic              d_tsb_split_o,
  output logic [SIZE_W-1:0] d_tsb_size_o
);
  localparam int unsigned NUM_SIDES = 2;
  localparam int unsigned BASE_W    = DATA_W - TSB_BASE_LSB;

  logic [NUM_SIDES-1:0]             side_upd;
  logic [NUM_SIDES-1:0][DATA_W-1:0] side_stat, side_addr;
  logic [NUM_SIDES-1:0][DATA_W-1:0] side_rdata, side_tag, side_tsb;
  logic [NUM_SIDES-1:0][DATA_W-1:0] side_base;
  logic [NUM_SIDES-1:0][CTX_W-1:0]  side_ctx;

  assign side_upd  = {d_flt_upd_i, i_flt_upd_i};
  assign side_stat = {d_flt_status_i, i_flt_status_i};
  assign side_addr = {d_flt_addr_i, i_flt_addr_i};

  generate
    for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
      mmu_creg_bank #(
        .IS_DATA (g == 1),
        .DATA_W  (DATA_W),
        .IDX_W   (IDX_W),
        .CTX_W   (CTX_W)
      ) i_bank (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .we_i         (acc_we_i && (acc_dside_i == (g == 1))),
        .idx_i        (acc_idx_i),
        .wdata_i      (acc_wdata_i),
        .flt_upd_i    (side_upd[g]),
        .flt_status_i (side_stat[g]),
        .flt_addr_i   (side_addr[g]),
        .rdata_o      (side_rdata[g]),
        .tag_access_o (side_tag[g]),
        .pri_ctx_o    (side_ctx[g]),
        .tsb_o        (side_tsb[g])
      );
      assign side_base[g] = {side_tsb[g][DATA_W-1:TSB_BASE_LSB], {TSB_BASE_LSB{1'b0}}};
    end
  endgenerate

  assign acc_rdata_o = side_rdata[acc_dside_i];

  // both sides translate with the data-side primary context
  assign xl_ctx_o = side_ctx[1];

  assign i_tag_access_o = side_tag[0];
  assign i_tsb_base_o   = side_base[0];
  assign i_tsb_split_o  = side_tsb[0][TSB_SPLIT_BIT];
  assign i_tsb_size_o   = side_tsb[0][SIZE_W-1:0];
  assign d_tag_access_o = side_tag[1];
  assign d_tsb_base_o   = side_base[1];
  assign d_tsb_split_o  = side_tsb[1][TSB_SPLIT_BIT];
  assign d_tsb_size_o   = side_tsb[1][SIZE_W-1:0];

  assert_ctx_follow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_we_i && acc_dside_i && (acc_idx_i == IDX_W'(SLOT_PCTX)))
      |=> (xl_ctx_o == $past(acc_wdata_i[CTX_W-1:0])));

  assert_side_isolate_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_we_i && !acc_dside_i) |=> ($stable(d_tag_access_o) && $stable(xl_ctx_o)));

  assert_base_low_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (i_tsb_base_o[TSB_BASE_LSB-1:0] == '0) && (d_tsb_base_o[TSB_BASE_LSB-1:0] == '0));

  logic unused_base_w;
  assign unused_base_w = (BASE_W == 0);
endmodule

// File: tb/test_mmu_creg_file.sv
module test_mmu_creg_file;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        acc_we_i = 1'b0;
  logic        acc_dside_i = 1'b0;
  logic [3:0]  acc_idx_i = '0;
  logic [63:0] acc_wdata_i = '0;
  logic [63:0] acc_rdata_o;
  logic        i_flt_upd_i = 1'b0;
  logic [63:0] i_flt_status_i = '0;
  logic [63:0] i_flt_addr_i = '0;
  logic        d_flt_upd_i = 1'b0;
  logic [63:0] d_flt_status_i = '0;
  logic [63:0] d_flt_addr_i = '0;
  logic [12:0] xl_ctx_o;
  logic [63:0] i_tag_access_o, i_tsb_base_o, d_tag_access_o, d_tsb_base_o;
  logic        i_tsb_split_o, d_tsb_split_o;
  logic [3:0]  i_tsb_size_o, d_tsb_size_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [63:0] mdl [2][16];

  always #5 clk_i = ~clk_i;

  mmu_creg_file i_mmu_creg_file (.*);

  function automatic logic [63:0] tag_tgt(input logic [63:0] t);
    return ({51'd0, t[12:0]} << 48) | (t >> 22);
  endfunction

  function automatic logic [63:0] exp_rd(input int s, input int idx);
    if (idx == 0) return tag_tgt(mdl[s][6]);
    if (idx > 8) return 64'd0;
    return mdl[s][idx];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic mdl_apply(input logic we, input logic side, input int idx, input logic [63:0] wd,
                           input logic iu, input logic [63:0] ist, input logic [63:0] ia,
                           input logic du, input logic [63:0] dst, input logic [63:0] da);
    int s = side ? 1 : 0;
    if (we) begin
      case (idx)
        1, 2, 4, 7, 8: if (s == 1) mdl[s][idx] = wd;
        3: begin
          mdl[s][3] = wd[0] ? wd : 64'd0;
          if (s == 1 && !wd[0]) mdl[1][4] = 64'd0;
        end
        5, 6: mdl[s][idx] = wd;
        default: ;
      endcase
    end
    if (iu) begin mdl[0][3] = ist; mdl[0][4] = ia; end
    if (du) begin mdl[1][3] = dst; mdl[1][4] = da; end
  endtask

  // called just after a falling edge
  task automatic cyc(input logic we, input logic side, input int idx, input logic [63:0] wd,
                     input logic iu, input logic [63:0] ist, input logic [63:0] ia,
                     input logic du, input logic [63:0] dst, input logic [63:0] da);
    acc_we_i = we; acc_dside_i = side; acc_idx_i = 4'(idx); acc_wdata_i = wd;
    i_flt_upd_i = iu; i_flt_status_i = ist; i_flt_addr_i = ia;
    d_flt_upd_i = du; d_flt_status_i = dst; d_flt_addr_i = da;
    @(posedge clk_i);
    mdl_apply(we, side, idx, wd, iu, ist, ia, du, dst, da);
    #1;
    acc_we_i = 1'b0; i_flt_upd_i = 1'b0; d_flt_upd_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic wr(input logic side, input int idx, input logic [63:0] wd);
    cyc(1'b1, side, idx, wd, 1'b0, '0, '0, 1'b0, '0, '0);
  endtask

  task automatic rd_chk(input string req, input logic side, input int idx);
    acc_dside_i = side; acc_idx_i = 4'(idx);
    #1;
    check(req, acc_rdata_o, exp_rd(side ? 1 : 0, idx));
  endtask

  task automatic exp_chk(input string req);
    check({req, " ctx"}, {51'd0, xl_ctx_o}, {51'd0, mdl[1][1][12:0]});
    check({req, " i_tag"}, i_tag_access_o, mdl[0][6]);
    check({req, " d_tag"}, d_tag_access_o, mdl[1][6]);
    check({req, " i_base"}, i_tsb_base_o, {mdl[0][5][63:13], 13'd0});
    check({req, " d_base"}, d_tsb_base_o, {mdl[1][5][63:13], 13'd0});
    check({req, " split/size"}, {54'd0, i_tsb_split_o, i_tsb_size_o, d_tsb_split_o, d_tsb_size_o},
          {54'd0, mdl[0][5][12], mdl[0][5][3:0], mdl[1][5][12], mdl[1][5][3:0]});
  endtask

  initial begin
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < 16; k++) mdl[s][k] = 64'd0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < 16; k++) rd_chk("R1 reset read", s[0], k);
    exp_chk("R1 reset export");
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 tag target literal and write ignore
    wr(1'b1, 6, 64'hFFFF_FFFF_FFFF_FFFF);
    acc_dside_i = 1'b1; acc_idx_i = 4'd0; #1;
    check("R2 tag target literal", acc_rdata_o, 64'h1FFF_03FF_FFFF_FFFF);
    wr(1'b1, 0, 64'h1234_5678_9ABC_DEF0);
    wr(1'b0, 0, 64'h0F0F_0F0F_0F0F_0F0F);
    rd_chk("R2 index0 write ignored d", 1'b1, 0);
    rd_chk("R2 index0 write ignored i", 1'b0, 0);

    // R3 fault status write rule
    wr(1'b0, 3, 64'hABCD_0000_0000_0ABE);
    acc_dside_i = 1'b0; acc_idx_i = 4'd3; #1;
    check("R3 bit0 clear stores zero", acc_rdata_o, 64'd0);
    wr(1'b0, 3, 64'h0000_0000_0000_ABC1);
    acc_dside_i = 1'b0; acc_idx_i = 4'd3; #1;
    check("R3 bit0 set stores value", acc_rdata_o, 64'h0000_0000_0000_ABC1);

    // R4 data-side clear of fault address
    wr(1'b1, 4, 64'h0000_0000_0000_1234);
    wr(1'b1, 3, 64'h5);
    acc_dside_i = 1'b1; acc_idx_i = 4'd4; #1;
    check("R4 bit0 set keeps addr", acc_rdata_o, 64'h1234);
    wr(1'b1, 3, 64'h4);
    acc_dside_i = 1'b1; acc_idx_i = 4'd4; #1;
    check("R4 bit0 clear clears addr", acc_rdata_o, 64'd0);

    // R5 instruction read-only / absent slots
    cyc(1'b0, 1'b0, 0, '0, 1'b1, 64'h11, 64'hCAFE, 1'b0, '0, '0);
    wr(1'b1, 1, 64'h0000_0000_0000_0155);
    foreach (mdl[0][k]) if (k inside {1, 2, 4, 7, 8}) wr(1'b0, k, 64'hDEAD_BEEF_0000_0000 | 64'(k));
    acc_dside_i = 1'b0; acc_idx_i = 4'd4; #1;
    check("R5 ro fault addr kept", acc_rdata_o, 64'hCAFE);
    for (int k = 1; k <= 8; k++) if (k inside {1, 2, 7, 8}) rd_chk("R5 absent slot zero", 1'b0, k);
    check("R9 ctx unaffected by i write", {51'd0, xl_ctx_o}, 64'h155);

    // R6 / R7 stores
    for (int k = 1; k <= 8; k++) if (k != 3) wr(1'b1, k, {32'hA5A5_0000 | 32'(k), 32'h1357_9BDF});
    for (int k = 1; k <= 8; k++) if (k != 3) rd_chk("R6 data slot readback", 1'b1, k);
    wr(1'b0, 5, 64'hFEDC_BA98_7654_3FFF);
    wr(1'b0, 6, 64'h0123_4567_89AB_CDEF);
    rd_chk("R7 i base readback", 1'b0, 5);
    rd_chk("R7 i tag readback", 1'b0, 6);
    rd_chk("R2 i tag target", 1'b0, 0);
    exp_chk("R10 exports");

    // R8 high indices
    for (int k = 9; k < 16; k++) wr(k[0], k, 64'hFFFF_FFFF_FFFF_FFFF);
    for (int k = 9; k < 16; k++) begin
      rd_chk("R8 high index zero d", 1'b1, k);
      rd_chk("R8 high index zero i", 1'b0, k);
    end
    for (int k = 1; k <= 8; k++) rd_chk("R8 low slots untouched", 1'b1, k);

    // R11 collisions
    cyc(1'b1, 1'b1, 3, 64'h6, 1'b0, '0, '0, 1'b1, 64'h99, 64'h55);
    rd_chk("R11 status wins over clear", 1'b1, 3);
    rd_chk("R11 addr wins over clear", 1'b1, 4);
    cyc(1'b1, 1'b1, 4, 64'h777, 1'b1, 64'h31, 64'h32, 1'b1, 64'h41, 64'h42);
    rd_chk("R11 addr wins over write", 1'b1, 4);
    rd_chk("R11 i status capture", 1'b0, 3);
    rd_chk("R11 i addr capture", 1'b0, 4);

    // R12 side isolation
    wr(1'b0, 6, 64'h1111_2222_3333_4444);
    wr(1'b0, 5, 64'h0);
    exp_chk("R12 isolation");
    rd_chk("R12 d tag kept", 1'b1, 6);

    // constrained random mix
    for (int it = 0; it < 3000; it++) begin
      logic we, side, iu, du;
      int idx;
      we   = ($urandom_range(3, 0) != 0);
      side = 1'($urandom_range(1, 0));
      idx  = ($urandom_range(3, 0) == 0) ? int'($urandom_range(15, 0)) : int'($urandom_range(8, 0));
      iu   = ($urandom_range(3, 0) == 0);
      du   = ($urandom_range(3, 0) == 0);
      cyc(we, side, idx, {$urandom, $urandom}, iu, {$urandom, $urandom}, {$urandom, $urandom},
          du, {$urandom, $urandom}, {$urandom, $urandom});
      rd_chk("R11 random status d", 1'b1, 3);
      rd_chk("R4 random addr d", 1'b1, 4);
      rd_chk("R3 random status i", 1'b0, 3);
      rd_chk("R6 random slot", side, idx);
      rd_chk("R2 random target", ~side, 0);
      if (it % 16 == 0) exp_chk("R10 random exports");
    end

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule